// File: doc/BRIEF.md
# Receive Packet Integrity Monitor

This block watches the user side of a packet receive interface that presents up to four 64-bit words per clock. The monitor only needs the sideband of each beat: a valid-word count, a start-of-packet strobe, a channel number, a 4-bit end code, a per-packet error flag and a real-time CRC24 error strobe. It follows one packet at a time, adds up its byte length, and when the packet closes it issues a single-cycle completion record. The record carries the channel, the length and a good or errored verdict.

The block keeps four saturating counters: good packets, errored packets, CRC24 error events and protocol violations. The CRC24 counter follows its own strobe and counts every cycle that strobe is high, including cycles that carry only idle words. The per-packet error flag never feeds it. A synchronous clear input resets all counters without disturbing packet tracking.

A beat is any cycle whose valid-word count is non-zero. In the end code, bit 3 marks end of packet and bits [2:0] give the bytes used in the last valid word, where 0 stands for 8. Code 4'b0001 also ends the packet and marks it errored.

Top module: `rx_pkt_monitor`

## Requirements
- R1: The channel present on a beat with start-of-packet high is captured, and the record of that packet reports it, whatever the channel input shows on later beats.
- R2: Each non-final beat adds 8 bytes per valid word. A final beat with end code bit 3 set adds 8 × (count − 1) plus bits [2:0] of the code, where 0 counts as 8. A final beat with code 4'b0001 adds 8 × count. For example, counts 4, 4, 3 followed by code 4'b1011 give 83 bytes.
- R3: A packet is reported errored if its end code is 4'b0001 or if the error flag was high on any of its beats. Otherwise it is reported good. An end code of 4'b0000 never ends a packet.
- R4: The record valid is high for exactly one cycle, in the cycle after the beat that closes the packet. It is low in every other cycle.
- R5: A start-of-packet beat that arrives while a packet is open closes the open packet with an errored record holding its length so far, and starts the new packet. If that same beat also carries an end code, the new packet is discarded and counted as a protocol violation.
- R6: A beat without start-of-packet that arrives while no packet is open produces no record and increments the violation counter.
- R7: The CRC24 counter increases by one for each cycle in which the CRC24 strobe is high, whether or not data is flowing. It is unaffected by the per-packet error flag.
- R8: Each good record increments the good counter, and each errored record increments the errored counter.
- R9: Every counter holds at its all-ones value instead of wrapping.
- R10: The clear input sets all four counters to zero on the next edge, and it takes precedence over any increment in the same cycle.
- R11: While reset is low, the record valid is low and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous counter clear |
| rx_sop | input | 1 | Start of packet on this beat |
| rx_chan | input | CH_W | Destination channel, valid with rx_sop |
| rx_nwords | input | $clog2(WORDS+1) | Valid 64-bit words in this beat; 0 means no beat |
| rx_eop_code | input | 4 | End code: 0000 not last, 0001 errored end, 1bbb good end with bbb bytes in last word |
| rx_err | input | 1 | Packet error flag |
| rx_crc_err | input | 1 | Real-time CRC24 error strobe |
| rec_vld | output | 1 | Completion record valid (one cycle) |
| rec_chan | output | CH_W | Record channel |
| rec_len | output | LEN_W | Record byte length |
| rec_bad | output | 1 | Record verdict, 1 = errored |
| good_cnt | output | CNT_W | Good packet counter |
| bad_cnt | output | CNT_W | Errored packet counter |
| crc_cnt | output | CNT_W | CRC24 error event counter |
| viol_cnt | output | CNT_W | Protocol violation counter |

## Verification
The bench builds the monitor with CNT_W = 3, so every counter reaches its ceiling of 7 after only a handful of events. That keeps the saturation check on the CRC24 and violation counters short. WORDS stays at 4 and LEN_W at 16, which lets the bench use the 83-byte three-beat packet, single-beat packets and mid-packet aborts with exact byte totals. CH_W stays at 8, so channel capture is checked against values that differ between consecutive packets.

// File: rtl/rx_pkt_monitor.sv
module rx_pkt_monitor #(
  parameter int WORDS = 4,
  parameter int CH_W  = 8,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16,
  localparam int NW_W = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rx_sop,
  input  logic [CH_W-1:0]  rx_chan,
  input  logic [NW_W-1:0]  rx_nwords,
  input  logic [3:0]       rx_eop_code,
  input  logic             rx_err,
  input  logic             rx_crc_err,
  output logic             rec_vld,
  output logic [CH_W-1:0]  rec_chan,
  output logic [LEN_W-1:0] rec_len,
  output logic             rec_bad,
  output logic [CNT_W-1:0] good_cnt,
  output logic [CNT_W-1:0] bad_cnt,
  output logic [CNT_W-1:0] crc_cnt,
  output logic [CNT_W-1:0] viol_cnt
);

  logic             open_q, bad_q;
  logic [CH_W-1:0]  chan_q;
  logic [LEN_W-1:0] len_q;

  wire beat     = rx_nwords != '0;
  wire code_bad = rx_eop_code == 4'b0001;
  wire code_end = rx_eop_code[3] | code_bad;
  wire start    = beat & rx_sop;
  wire abort    = start & open_q;
  wire cont     = beat & ~rx_sop & open_q;
  wire orphan   = beat & ~rx_sop & ~open_q;

  wire [3:0]       last_b = (rx_eop_code[2:0] == 3'd0) ? 4'd8 : {1'b0, rx_eop_code[2:0]};
  wire [LEN_W-1:0] full_b = LEN_W'(rx_nwords) << 3;
  wire [LEN_W-1:0] beat_b = (code_end & ~code_bad) ? (full_b - LEN_W'(8) + LEN_W'(last_b)) : full_b;
  wire [LEN_W:0]   sum    = {1'b0, len_q} + {1'b0, beat_b};
  wire [LEN_W-1:0] len_add = sum[LEN_W] ? '1 : sum[LEN_W-1:0];

  logic             n_vld, n_bad;
  logic [CH_W-1:0]  n_chan;
  logic [LEN_W-1:0] n_len;

  always_comb begin
    n_vld  = 1'b0;
    n_bad  = 1'b0;
    n_chan = chan_q;
    n_len  = len_q;
    if (abort) begin
      n_vld = 1'b1;
      n_bad = 1'b1;
    end else if (start & code_end) begin
      n_vld  = 1'b1;
      n_chan = rx_chan;
      n_len  = beat_b;
      n_bad  = rx_err | code_bad;
    end else if (cont & code_end) begin
      n_vld = 1'b1;
      n_len = len_add;
      n_bad = bad_q | rx_err | code_bad;
    end
  end

  wire good_inc = n_vld & ~n_bad;
  wire bad_inc  = n_vld & n_bad;
  wire viol_inc = orphan | (abort & code_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      bad_q  <= 1'b0;
      chan_q <= '0;
      len_q  <= '0;
    end else if (start & ~code_end) begin
      open_q <= 1'b1;
      chan_q <= rx_chan;
      len_q  <= beat_b;
      bad_q  <= rx_err;
    end else if (abort) begin
      open_q <= 1'b0;
    end else if (cont) begin
      if (code_end) begin
        open_q <= 1'b0;
      end else begin
        len_q <= len_add;
        bad_q <= bad_q | rx_err;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_vld  <= 1'b0;
      rec_bad  <= 1'b0;
      rec_chan <= '0;
      rec_len  <= '0;
    end else begin
      rec_vld <= n_vld;
      if (n_vld) begin
        rec_bad  <= n_bad;
        rec_chan <= n_chan;
        rec_len  <= n_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_cnt <= '0;
      bad_cnt  <= '0;
      crc_cnt  <= '0;
      viol_cnt <= '0;
    end else if (clr) begin
      good_cnt <= '0;
      bad_cnt  <= '0;
      crc_cnt  <= '0;
      viol_cnt <= '0;
    end else begin
      if (good_inc && good_cnt != '1)   good_cnt <= good_cnt + 1'b1;
      if (bad_inc && bad_cnt != '1)     bad_cnt  <= bad_cnt + 1'b1;
      if (rx_crc_err && crc_cnt != '1)  crc_cnt  <= crc_cnt + 1'b1;
      if (viol_inc && viol_cnt != '1)   viol_cnt <= viol_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rx_pkt_monitor_chk.sv
module rx_pkt_monitor_chk #(
  parameter int CNT_W = 16,
  parameter int NW_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             rx_sop,
  input logic [NW_W-1:0]  rx_nwords,
  input logic [3:0]       rx_eop_code,
  input logic             rx_crc_err,
  input logic             open_q,
  input logic             rec_vld,
  input logic             rec_bad,
  input logic [CNT_W-1:0] good_cnt,
  input logic [CNT_W-1:0] bad_cnt,
  input logic [CNT_W-1:0] crc_cnt,
  input logic [CNT_W-1:0] viol_cnt
);

  wire beat = rx_nwords != '0;

  assert_rec_after_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld |-> $past(beat && (rx_eop_code[3] || rx_eop_code == 4'b0001 || (rx_sop && open_q))));

  assert_abort_errored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && rx_sop && open_q) |=> (rec_vld && rec_bad));

  assert_orphan_no_rec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !rx_sop && !open_q) |=> !rec_vld);

  assert_crc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && rx_crc_err && crc_cnt != '1) |=> crc_cnt == $past(crc_cnt) + 1'b1);

  assert_crc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !rx_crc_err) |=> $stable(crc_cnt));

  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && viol_cnt == '1) |=> viol_cnt == '1);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (good_cnt == '0 && bad_cnt == '0 && crc_cnt == '0 && viol_cnt == '0));

endmodule

bind rx_pkt_monitor rx_pkt_monitor_chk #(.CNT_W(CNT_W), .NW_W(NW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .rx_sop(rx_sop), .rx_nwords(rx_nwords),
  .rx_eop_code(rx_eop_code), .rx_crc_err(rx_crc_err), .open_q(open_q),
  .rec_vld(rec_vld), .rec_bad(rec_bad), .good_cnt(good_cnt), .bad_cnt(bad_cnt),
  .crc_cnt(crc_cnt), .viol_cnt(viol_cnt)
);

// File: tb/test_rx_pkt_monitor.sv
module test_rx_pkt_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 3;
  localparam int NV = 9;

  logic clk = 0, rst_n = 0, clr = 0;
  logic rx_sop = 0, rx_err = 0, rx_crc_err = 0;
  logic [7:0] rx_chan = 0;
  logic [2:0] rx_nwords = 0;
  logic [3:0] rx_eop_code = 0;
  logic rec_vld, rec_bad;
  logic [7:0] rec_chan;
  logic [15:0] rec_len;
  logic [CNT_W-1:0] good_cnt, bad_cnt, crc_cnt, viol_cnt;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pkt_monitor #(.WORDS(4), .CH_W(8), .LEN_W(16), .CNT_W(CNT_W)) i_rx_pkt_monitor (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rx_sop(rx_sop), .rx_chan(rx_chan),
    .rx_nwords(rx_nwords), .rx_eop_code(rx_eop_code), .rx_err(rx_err),
    .rx_crc_err(rx_crc_err), .rec_vld(rec_vld), .rec_chan(rec_chan), .rec_len(rec_len),
    .rec_bad(rec_bad), .good_cnt(good_cnt), .bad_cnt(bad_cnt), .crc_cnt(crc_cnt),
    .viol_cnt(viol_cnt)
  );

  // {sop, chan, nwords, code, err, crc, exp_vld, exp_chan, exp_len, exp_bad}
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 8'd2, 3'd4, 4'b0000, 1'b0, 1'b0, 1'b0, 8'd0, 16'd0,  1'b0},
    {1'b0, 8'd9, 3'd4, 4'b0000, 1'b0, 1'b0, 1'b0, 8'd0, 16'd0,  1'b0},
    {1'b0, 8'd9, 3'd3, 4'b1011, 1'b1, 1'b0, 1'b1, 8'd2, 16'd83, 1'b1},
    {1'b0, 8'd0, 3'd0, 4'b0000, 1'b0, 1'b1, 1'b0, 8'd0, 16'd0,  1'b0},
    {1'b0, 8'd0, 3'd0, 4'b0000, 1'b0, 1'b1, 1'b0, 8'd0, 16'd0,  1'b0},
    {1'b1, 8'd3, 3'd4, 4'b0000, 1'b0, 1'b0, 1'b0, 8'd0, 16'd0,  1'b0},
    {1'b0, 8'd7, 3'd2, 4'b1000, 1'b0, 1'b0, 1'b1, 8'd3, 16'd48, 1'b0},
    {1'b1, 8'd5, 3'd1, 4'b1101, 1'b0, 1'b0, 1'b1, 8'd5, 16'd5,  1'b0},
    {1'b1, 8'd7, 3'd4, 4'b0001, 1'b0, 1'b0, 1'b1, 8'd7, 16'd32, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic beat(input logic sop, input logic [7:0] ch, input logic [2:0] nw,
                      input logic [3:0] code, input logic err, input logic crc);
    @(negedge clk);
    rx_sop = sop; rx_chan = ch; rx_nwords = nw; rx_eop_code = code;
    rx_err = err; rx_crc_err = crc;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input logic crc);
    beat(1'b0, 8'd0, 3'd0, 4'b0000, 1'b0, crc);
  endtask

  task automatic do_clr(input logic crc);
    @(negedge clk);
    clr = 1; rx_sop = 0; rx_nwords = 0; rx_eop_code = 0; rx_err = 0; rx_crc_err = crc;
    @(posedge clk);
    #1;
    @(negedge clk);
    clr = 0;
  endtask

  task automatic rec(input string req, input logic [7:0] ch, input logic [15:0] len, input logic bad);
    chk({req, " rec_vld"}, rec_vld, 1);
    chk({req, " rec_chan"}, rec_chan, ch);
    chk({req, " rec_len"}, rec_len, len);
    chk({req, " rec_bad"}, rec_bad, bad);
  endtask

  task automatic cnts(input string req, input int g, input int b, input int c, input int v);
    chk({req, " good_cnt"}, good_cnt, g);
    chk({req, " bad_cnt"}, bad_cnt, b);
    chk({req, " crc_cnt"}, crc_cnt, c);
    chk({req, " viol_cnt"}, viol_cnt, v);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 rec_vld in reset", rec_vld, 0);
    cnts("R11 reset", 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      beat(v[43], v[42:35], v[34:32], v[31:28], v[27], v[26]);
      if (v[25]) rec("R1 R2 R3 R4 vector", v[24:17], v[16:1], v[0]);
      else chk("R4 no record on vector", rec_vld, 0);
    end
    cnts("R7 R8 after vectors", 2, 2, 2, 0);

    idle(0);
    chk("R4 record lasts one cycle", rec_vld, 0);

    beat(1, 8'd9, 4, 4'b0000, 0, 0);
    beat(1, 8'd10, 4, 4'b0000, 0, 0);
    rec("R5 abort closes open packet", 8'd9, 16'd32, 1);
    beat(0, 8'd0, 1, 4'b1000, 0, 0);
    rec("R5 new packet after abort", 8'd10, 16'd40, 0);

    beat(1, 8'd1, 4, 4'b0000, 0, 0);
    beat(1, 8'd2, 1, 4'b1000, 0, 0);
    rec("R5 abort with ending sop beat", 8'd1, 16'd32, 1);
    chk("R5 discarded packet violation", viol_cnt, 1);

    beat(0, 8'd0, 4, 4'b1000, 0, 0);
    chk("R6 orphan beat no record", rec_vld, 0);
    chk("R6 orphan beat violation", viol_cnt, 2);

    beat(1, 8'd4, 4, 4'b0000, 1, 0);
    beat(0, 8'd0, 1, 4'b1010, 0, 0);
    rec("R3 error flag on early beat", 8'd4, 16'd34, 1);
    cnts("R8 totals", 3, 5, 2, 2);

    do_clr(0);
    cnts("R10 clear", 0, 0, 0, 0);
    idle(1); idle(1); idle(1);
    chk("R7 crc counted while idle", crc_cnt, 3);
    beat(1, 8'd6, 4, 4'b1000, 0, 1);
    rec("R7 crc strobe does not mark packet", 8'd6, 16'd32, 0);
    beat(1, 8'd6, 1, 4'b1000, 1, 0);
    rec("R3 err flag errored single beat", 8'd6, 16'd8, 1);
    cnts("R7 err flag leaves crc", 1, 1, 4, 0);

    for (int k = 0; k < 10; k++) idle(1);
    chk("R9 crc saturates", crc_cnt, 7);
    for (int k = 0; k < 9; k++) beat(0, 8'd0, 2, 4'b0000, 0, 0);
    chk("R9 violation saturates", viol_cnt, 7);

    do_clr(1);
    cnts("R10 clear beats increment", 0, 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule